// File: doc/BRIEF.md
# Sample-to-Voltage BCD Converter

This block turns an 8-bit unsigned converter sample into a three-digit packed BCD voltage reading of the form X.XX volts, ready for a digit display driver. Each input step is worth 2 hundredths of a volt. Binary-to-decimal conversion is done without division and without shift-and-add-3. The sample is split into its two nibbles. Each nibble is mapped through its own constant BCD-valued table, and the two 12-bit BCD partial values are then summed digit by digit with decimal adjustment and carry.

Data enters and leaves on valid/ready streams through a two-stage pipeline. Stage one registers the two table lookups. Stage two registers the decimal-adjusted sum, after an optional per-digit calibration step. The calibration applies a signed offset to each digit and handles BCD borrow and carry fully. It is off by default and is enabled by parameter, for example to correct for a converter reference near 4.8 V instead of 5 V.

Back-pressure rules: a sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole pipeline holds its contents and `in_ready` is low. With `out_ready` held high, `in_ready` stays high and one sample is accepted every clock.

Top module: `adc_bcd_volt`

## Requirements
- R1: A sample whose upper nibble is 0 and whose lower nibble is n gives the BCD of n×2 hundredths (n=4 gives 0x008, n=0xF gives 0x030, n=0 gives 0x000).
- R2: A sample whose lower nibble is 0 and whose upper nibble is n gives the BCD of n×32 hundredths (n=1 gives 0x032, n=0xB gives 0x352, n=0xF gives 0x480).
- R3: `out_bcd` holds units in bits [11:8], tenths in [7:4] and hundredths in [3:0]. Every digit of a valid result is 0..9. When the two hundredths parts sum above 9, the digit is corrected by 6 and 1 is carried into tenths.
- R4: When the tenths parts plus the incoming carry exceed 9, the digit is corrected by 6 and 1 is carried into units. With calibration off, every sample s gives the BCD of 2×s.
- R5: With calibration off, sample 0xB4 gives 0x360, 0xFF gives 0x510 and 0x00 gives 0x000. No result exceeds 0x510.
- R6: With `out_ready` high, a sample accepted on one edge appears with `out_valid` high after exactly the second following edge, and back-to-back samples stream at one per clock.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_bcd` stay unchanged on every edge.
- R8: Once stalled results drain and no sample is offered, `out_valid` falls and `in_ready` is high. Results leave in the order the samples were accepted.
- R9: With calibration enabled (offsets −2 tenths and +1 hundredth, i.e. −19 hundredths), sample s gives the BCD of 2×s−19, computed with digit borrow and carry. A result below zero is clamped to 0x000 and one above 999 to 0x999.
- R10: A synchronous active-low reset clears `out_valid`, and after reset `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this edge |
| in_sample | input | 8 | Unsigned converter sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_bcd | output | 12 | Packed BCD volts: units, tenths, hundredths |

## Verification
The assertions assume that reset is held low across at least one rising edge from time zero, and that `out_ready` and `in_valid` are free inputs. The assertions do not require the producer to hold a sample steady while it is refused. The stimulus changes every input only on falling edges and keeps reset low for several cycles at start. It only offers a sample in ways the handshake allows, so each accepted sample, and the edge at which it was accepted, can be known from the inputs alone.

// File: rtl/adc_bcd_pkg.sv
package adc_bcd_pkg;
  localparam int BCD_DIGITS = 3;
  localparam int BCD_W      = 4 * BCD_DIGITS;

  typedef logic [BCD_W-1:0] bcd_word_t;

  // Elaboration-time conversion of a small non-negative integer to packed BCD.
  function automatic bcd_word_t int_to_bcd(input int value);
    bcd_word_t r;
    int        rem;
    rem = value;
    r   = '0;
    for (int d = 0; d < BCD_DIGITS; d++) begin
      r[4*d +: 4] = 4'(rem % 10);
      rem         = rem / 10;
    end
    return r;
  endfunction
endpackage

// File: rtl/nibble_lut.sv
module nibble_lut
  import adc_bcd_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int WEIGHT = 2
) (
  input  logic [NIB_W-1:0] nib,
  output bcd_word_t        part
);
  localparam int ENTRIES = 1 << NIB_W;

  always_comb begin
    part = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (nib == i[NIB_W-1:0]) part = int_to_bcd(i * WEIGHT);
    end
  end
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import adc_bcd_pkg::*;
(
  input  bcd_word_t a,
  input  bcd_word_t b,
  output bcd_word_t sum,
  output logic      carry_out
);
  logic [BCD_DIGITS:0] cy;
  assign cy[0] = 1'b0;

  for (genvar g = 0; g < BCD_DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    assign raw       = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, cy[g]};
    assign cy[g+1]   = raw > 5'd9;
    assign sum[4*g +: 4] = cy[g+1] ? (raw[3:0] + 4'd6) : raw[3:0];
  end

  assign carry_out = cy[BCD_DIGITS];
endmodule

// File: rtl/bcd_calib.sv
module bcd_calib
  import adc_bcd_pkg::*;
#(
  parameter bit CAL_EN         = 1'b0,
  parameter int CAL_UNITS      = 0,
  parameter int CAL_TENTHS     = -2,
  parameter int CAL_HUNDREDTHS = 1
) (
  input  bcd_word_t raw,
  output bcd_word_t trimmed
);
  if (!CAL_EN) begin : g_bypass
    assign trimmed = raw;
  end else begin : g_trim
    localparam int OFS [BCD_DIGITS] = '{CAL_HUNDREDTHS, CAL_TENTHS, CAL_UNITS};
    bcd_word_t res;
    int        t;
    int        c;

    always_comb begin
      res = '0;
      c   = 0;
      t   = 0;
      for (int d = 0; d < BCD_DIGITS; d++) begin
        t = int'(raw[4*d +: 4]) + OFS[d] + c;
        if (t > 9) begin
          t = t - 10;
          c = 1;
        end else if (t < 0) begin
          t = t + 10;
          c = -1;
        end else begin
          c = 0;
        end
        res[4*d +: 4] = 4'(t);
      end
      if (c < 0)      trimmed = '0;
      else if (c > 0) trimmed = {BCD_DIGITS{4'd9}};
      else            trimmed = res;
    end
  end
endmodule

// File: rtl/adc_bcd_volt.sv
module adc_bcd_volt
  import adc_bcd_pkg::*;
#(
  parameter int SAMPLE_W       = 8,
  parameter int LSB_HUNDREDTHS = 2,
  parameter bit CAL_EN         = 1'b0,
  parameter int CAL_UNITS      = 0,
  parameter int CAL_TENTHS     = -2,
  parameter int CAL_HUNDREDTHS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BCD_W-1:0]    out_bcd
);
  localparam int NIB_W = SAMPLE_W / 2;
  localparam int NIBS  = 2;

  logic      advance;
  logic      s1_valid;
  bcd_word_t lut_part [NIBS];
  bcd_word_t s1_part  [NIBS];
  bcd_word_t add_sum;
  logic      add_cy;
  bcd_word_t sat_sum;
  bcd_word_t cal_sum;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    nibble_lut #(
      .NIB_W (NIB_W),
      .WEIGHT(LSB_HUNDREDTHS << (g * NIB_W))
    ) u_lut (
      .nib (in_sample[g*NIB_W +: NIB_W]),
      .part(lut_part[g])
    );
  end

  bcd_adder u_add (
    .a        (s1_part[0]),
    .b        (s1_part[1]),
    .sum      (add_sum),
    .carry_out(add_cy)
  );

  assign sat_sum = add_cy ? {BCD_DIGITS{4'd9}} : add_sum;

  bcd_calib #(
    .CAL_EN        (CAL_EN),
    .CAL_UNITS     (CAL_UNITS),
    .CAL_TENTHS    (CAL_TENTHS),
    .CAL_HUNDREDTHS(CAL_HUNDREDTHS)
  ) u_cal (
    .raw    (sat_sum),
    .trimmed(cal_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_part   <= '{default: '0};
      out_valid <= 1'b0;
      out_bcd   <= '0;
    end else if (advance) begin
      s1_valid  <= in_valid;
      if (in_valid) s1_part <= lut_part;
      out_valid <= s1_valid;
      if (s1_valid) out_bcd <= cal_sum;
    end
  end
endmodule

// File: rtl/adc_bcd_volt_chk.sv
module adc_bcd_volt_chk #(
  parameter bit CAL_EN = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [11:0] out_bcd
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R10

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bcd[11:8] <= 4'd9 && out_bcd[7:4] <= 4'd9 && out_bcd[3:0] <= 4'd9)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bcd)); // R7

  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ##1 out_valid); // R6

  AST_PLAIN_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    !CAL_EN && out_valid |-> out_bcd <= 12'h510); // R5
endmodule

bind adc_bcd_volt adc_bcd_volt_chk #(.CAL_EN(CAL_EN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bcd  (out_bcd)
);

// File: tb/tb_adc_bcd_volt.sv
`timescale 1ns/1ps
module tb_adc_bcd_volt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_sample;
  logic        out_ready;
  logic        in_ready, in_ready_c;
  logic        out_valid, out_valid_c;
  logic [11:0] out_bcd, out_bcd_c;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  adc_bcd_volt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready), .out_bcd(out_bcd)
  );

  adc_bcd_volt #(.CAL_EN(1'b1)) dut_cal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .in_sample(in_sample), .out_valid(out_valid_c), .out_ready(out_ready), .out_bcd(out_bcd_c)
  );

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [11:0] exp_plain(input int s);
    return to_bcd(2 * s);
  endfunction

  function automatic logic [11:0] exp_cal(input int s);
    int v;
    v = 2 * s - 19;
    if (v < 0) v = 0;
    if (v > 999) v = 999;
    return to_bcd(v);
  endfunction

  function automatic string req_of(input int s);
    int h, l;
    h = (s / 16) * 32;
    l = (s % 16) * 2;
    if (s / 16 == 0) return "R1";
    if (s % 16 == 0) return "R2";
    if (((h / 10) % 10) + ((l / 10) % 10) + (((h % 10) + (l % 10)) > 9 ? 1 : 0) > 9) return "R4";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 out_valid in reset", {11'b0, out_valid}, 12'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 in_ready after reset", {11'b0, in_ready}, 12'h1);
    check("R10 out_valid after reset", {11'b0, out_valid}, 12'h0);
  endtask

  // Drive one sample with free flow, return result two edges later.
  task automatic t_single(input int s, input logic [11:0] exp, input string req);
    out_ready = 1'b1; in_valid = 1'b1; in_sample = 8'(s);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " not early (R6)"}, {11'b0, out_valid}, 12'h0);
    @(negedge clk);
    check({req, " valid (R6)"}, {11'b0, out_valid}, 12'h1);
    check(req, out_bcd, exp);
    @(negedge clk);
  endtask

  task automatic t_anchors();
    t_single(8'hB4, 12'h360, "R5 0xB4");
    t_single(8'hFF, 12'h510, "R5 0xFF");
    t_single(8'h00, 12'h000, "R5 0x00");
    t_single(8'h0F, 12'h030, "R1 0x0F");
    t_single(8'hB0, 12'h352, "R2 0xB0");
  endtask

  task automatic t_sweep();
    out_ready = 1'b1;
    for (int i = 0; i < 258; i++) begin
      if (i == 1) check("R6 one edge not enough", {11'b0, out_valid}, 12'h0);
      if (i >= 2) begin
        check("R6 stream valid", {11'b0, out_valid}, 12'h1);
        check(req_of(i - 2), out_bcd, exp_plain(i - 2));
        check("R9 calibrated", out_bcd_c, exp_cal(i - 2));
      end
      in_valid  = (i < 256);
      in_sample = 8'(i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    in_valid = 1'b1; in_sample = 8'h10;
    @(negedge clk);
    in_sample = 8'h20;
    @(negedge clk);
    in_sample = 8'h30;
    check("R7 in_ready low on stall", {11'b0, in_ready}, 12'h0);
    check("R7 stalled value", out_bcd, 12'h032);
    repeat (3) @(negedge clk);
    check("R7 held valid", {11'b0, out_valid}, 12'h1);
    check("R7 held value", out_bcd, 12'h032);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 order second", out_bcd, 12'h064);
    @(negedge clk);
    check("R8 order third", out_bcd, 12'h096);
    @(negedge clk);
    check("R8 drained", {11'b0, out_valid}, 12'h0);
    check("R8 ready after drain", {11'b0, in_ready}, 12'h1);
  endtask

  task automatic t_calib_edges();
    check("R9 clamp low 0x00", exp_cal(0), 12'h000);
    t_single(8'h05, 12'h010, "R4 0x05 plain");
    check("R9 clamp 0x05", out_bcd_c, 12'h000);
    t_single(8'hB4, 12'h360, "R5 0xB4 again");
    check("R9 0xB4 trimmed", out_bcd_c, 12'h341);
    t_single(8'hFF, 12'h510, "R5 0xFF again");
    check("R9 0xFF trimmed", out_bcd_c, 12'h491);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_anchors();
    t_sweep();
    t_backpressure();
    t_calib_edges();
    finish_run();
  end
endmodule